// File: doc/BRIEF.md
# Audio DMA address generator

This block is the address side of one audio DMA channel. Its transfers fill or drain a contiguous ring buffer in memory. Software gives it three values:

- a base address;
- a protection address, which equals the base plus the buffer size and marks the end of the ring;
- a page word that carries a 4-bit period code.

When the channel is started, the block loads the base into its bus pointer. It then advances the pointer by one dword (4 bytes) for every dword the bus side accepts. When the pointer reaches the protection address it returns to the base.

On each accepted dword the block tests the address the pointer has just reached. If that address lands on a power-of-two boundary of 2^(5+L) bytes, where L is the period code, the block emits a one-cycle period pulse. The pulse sets a sticky status bit that software clears by writing a one.

In parallel the block offers burst requests to the bus master. The burst length is 2^n dwords for a 3-bit code n, and it is cut short so that a burst never runs past the protection address. A request is only raised once the channel FIFO can take or supply enough data. For capture that means enough valid dwords are stored. For playback it means enough empty slots are free. The current pointer is always visible. Address translation is not part of the block: its enable bit in the page word is ignored.

Top module: `audio_dma_addr_gen`

## Requirements
- R1: After reset `cur_ptr` is 0, and `req_valid`, `period_pulse` and `period_sts` are 0.
- R2: In the cycle after `xfer_en` rises, `cur_ptr` equals `cfg_base`. From the next cycle on, each cycle with `beat_ok` high adds 4 to `cur_ptr`.
- R3: When `cur_ptr + 4` equals `cfg_prot`, an accepted beat loads `cfg_base` into `cur_ptr` instead of the sum.
- R4: The period code L is `cfg_page[7:4]`. On an accepted beat whose address `cur_ptr + 4` (taken before any wrap) has its low 5+L bits all zero, `period_pulse` is high for the following cycle. L = 0 never produces a pulse. `cfg_page[11]` and all other page bits have no effect.
- R5: `period_sts` becomes 1 in the cycle after `period_pulse`. It returns to 0 in the cycle after `irq_clr` is high. When `irq_clr` and `period_pulse` are high in the same cycle, the status stays 1.
- R6: `req_len` equals the smaller of 2^`burst_code` dwords and (`cfg_prot` - `cur_ptr`)/4 dwords.
- R7: The threshold is 1, 4, 8 or 16 dwords for `thresh_code` 0, 1, 2 or 3. With `dir_write` = 1 (capture), `req_valid` needs `fifo_level` to be at least the threshold. With `dir_write` = 0 (playback), it needs FIFO_DEPTH - `fifo_level` to be at least the threshold.
- R8: While `xfer_en` is 0, `cur_ptr` holds its value, `beat_ok` is ignored and `req_valid` is 0.
- R9: `cfg_err` is 1 when `cfg_prot` <= `cfg_base`, or when bits [1:0] of either address are nonzero. While `cfg_err` is 1, `req_valid` is 0 and beats are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xfer_en | input | 1 | Channel run; a rising edge reloads the base |
| dir_write | input | 1 | 1 = capture (memory write), 0 = playback (memory read) |
| cfg_base | input | ADDR_W | Ring start byte address |
| cfg_prot | input | ADDR_W | Ring end byte address (base + size) |
| cfg_page | input | 12 | Page word; period code in [7:4] |
| burst_code | input | 3 | Burst length code, 2^n dwords |
| thresh_code | input | 2 | FIFO threshold code |
| fifo_level | input | LVL_W | Valid dwords held in the channel FIFO |
| beat_ok | input | 1 | One dword accepted by the bus side |
| irq_clr | input | 1 | Write-one-to-clear of the period status |
| cur_ptr | output | ADDR_W | Current bus address pointer |
| req_valid | output | 1 | Burst request |
| req_len | output | 8 | Burst length in dwords |
| period_pulse | output | 1 | One-cycle period event |
| period_sts | output | 1 | Sticky period status |
| cfg_err | output | 1 | Ring configuration invalid |

## Verification
Two events can fall in the same cycle. The first is the wrap back to the base and the period pulse: a ring of 64 bytes at a 64-byte-aligned base with L = 1 makes the crossing address equal to the protection address. The bench checks that the pointer returns to the base in the same cycle that the pulse appears. The second is a status clear that arrives while the pulse is high; it is judged by the status staying set.

// File: rtl/adg_pkg.sv
package adg_pkg;
  localparam int LEN_W = 8;

  // Low-bit mask of a 2^(5+lim) byte period window.
  function automatic logic [63:0] period_mask(input logic [3:0] lim);
    logic [6:0] sh;
    sh = {3'b000, lim} + 7'd5;
    return (64'd1 << sh) - 64'd1;
  endfunction

  function automatic logic [LEN_W-1:0] burst_dwords(input logic [2:0] code);
    return LEN_W'(1) << code;
  endfunction

  function automatic logic [4:0] thresh_dwords(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/adg_pointer.sv
module adg_pointer #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_en,
  input  logic              cfg_err,
  input  logic              beat_ok,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] prot,
  input  logic [3:0]        limit,
  output logic [ADDR_W-1:0] ptr,
  output logic              active,
  output logic              period_pulse
);
  import adg_pkg::*;

  logic              en_q;
  logic              start_ev;
  logic              beat_taken;
  logic [ADDR_W-1:0] step_addr;
  logic [ADDR_W-1:0] win_mask;
  logic              hits_prot;
  logic              on_boundary;

  assign start_ev    = xfer_en & ~en_q;
  assign active      = xfer_en & en_q & ~cfg_err;
  assign beat_taken  = active & beat_ok;
  assign step_addr   = ptr + ADDR_W'(4);
  assign hits_prot   = (step_addr == prot);
  assign win_mask    = ADDR_W'(period_mask(limit));
  assign on_boundary = (limit != 4'd0) && ((step_addr & win_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr          <= '0;
      en_q         <= 1'b0;
      period_pulse <= 1'b0;
    end else begin
      en_q         <= xfer_en;
      period_pulse <= beat_taken & on_boundary;
      if (start_ev)
        ptr <= base;
      else if (beat_taken)
        ptr <= hits_prot ? base : step_addr;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(ptr)); // R8
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && en_q && xfer_en) |=> $stable(ptr)); // R9
  AST_PULSE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> $past(beat_ok && active)); // R4
  AST_NO_PULSE_L0: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> ($past(limit) != 4'd0)); // R4
endmodule

// File: rtl/adg_burst.sv
module adg_burst #(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      dir_write,
  input  logic [LVL_W-1:0]          fifo_level,
  input  logic [2:0]                burst_code,
  input  logic [1:0]                thresh_code,
  input  logic [ADDR_W-1:0]         ptr,
  input  logic [ADDR_W-1:0]         prot,
  output logic                      req_valid,
  output logic [adg_pkg::LEN_W-1:0] req_len
);
  import adg_pkg::*;

  logic [ADDR_W-1:0] room_dw;
  logic [ADDR_W-1:0] want_dw;
  logic [LVL_W-1:0]  space;
  logic [LVL_W-1:0]  avail;
  logic [LVL_W-1:0]  thr;

  assign room_dw   = (prot - ptr) >> 2;
  assign want_dw   = ADDR_W'(burst_dwords(burst_code));
  assign req_len   = (room_dw < want_dw) ? room_dw[LEN_W-1:0] : want_dw[LEN_W-1:0];
  assign space     = LVL_W'(FIFO_DEPTH) - fifo_level;
  assign avail     = dir_write ? fifo_level : space;
  assign thr       = LVL_W'(thresh_dwords(thresh_code));
  assign req_valid = active && (avail >= thr) && (room_dw != '0);

  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((ADDR_W'(req_len) << 2) <= (prot - ptr))); // R6
  AST_CAPTURE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dir_write) |-> (fifo_level != '0)); // R7
endmodule

// File: rtl/adg_irq.sv
module adg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic period_pulse,
  input  logic irq_clr,
  output logic period_sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_sts <= 1'b0;
    else        period_sts <= (period_sts & ~irq_clr) | period_pulse;
  end

  AST_STS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |=> period_sts); // R5
  AST_STS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !period_pulse) |=> !period_sts); // R5
endmodule

// File: rtl/audio_dma_addr_gen.sv
module audio_dma_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xfer_en,
  input  logic                      dir_write,
  input  logic [ADDR_W-1:0]         cfg_base,
  input  logic [ADDR_W-1:0]         cfg_prot,
  input  logic [11:0]               cfg_page,
  input  logic [2:0]                burst_code,
  input  logic [1:0]                thresh_code,
  input  logic [LVL_W-1:0]          fifo_level,
  input  logic                      beat_ok,
  input  logic                      irq_clr,
  output logic [ADDR_W-1:0]         cur_ptr,
  output logic                      req_valid,
  output logic [adg_pkg::LEN_W-1:0] req_len,
  output logic                      period_pulse,
  output logic                      period_sts,
  output logic                      cfg_err
);
  logic active;
  logic [3:0] limit_code;

  assign limit_code = cfg_page[7:4];
  assign cfg_err = (cfg_prot <= cfg_base) | (|cfg_base[1:0]) | (|cfg_prot[1:0]);

  adg_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .cfg_err(cfg_err),
    .beat_ok(beat_ok), .base(cfg_base), .prot(cfg_prot), .limit(limit_code),
    .ptr(cur_ptr), .active(active), .period_pulse(period_pulse)
  );

  adg_burst #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .active(active), .dir_write(dir_write),
    .fifo_level(fifo_level), .burst_code(burst_code), .thresh_code(thresh_code),
    .ptr(cur_ptr), .prot(cfg_prot), .req_valid(req_valid), .req_len(req_len)
  );

  adg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .period_pulse(period_pulse),
    .irq_clr(irq_clr), .period_sts(period_sts)
  );

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en || cfg_err) |-> !req_valid); // R8
endmodule

// File: tb/test_audio_dma_addr_gen.sv
module test_audio_dma_addr_gen;
  localparam int AW = 32;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_en = 1'b0, dir_write = 1'b1, beat_ok = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_prot = '0;
  logic [11:0] cfg_page = '0;
  logic [2:0] burst_code = '0;
  logic [1:0] thresh_code = '0;
  logic [LW-1:0] fifo_level = '0;
  logic [AW-1:0] cur_ptr;
  logic req_valid, period_pulse, period_sts, cfg_err;
  logic [7:0] req_len;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;

  always #4 clk = ~clk;

  audio_dma_addr_gen #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) i_audio_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .dir_write(dir_write),
    .cfg_base(cfg_base), .cfg_prot(cfg_prot), .cfg_page(cfg_page),
    .burst_code(burst_code), .thresh_code(thresh_code), .fifo_level(fifo_level),
    .beat_ok(beat_ok), .irq_clr(irq_clr), .cur_ptr(cur_ptr), .req_valid(req_valid),
    .req_len(req_len), .period_pulse(period_pulse), .period_sts(period_sts),
    .cfg_err(cfg_err)
  );

  // burst, thresh, dir_write, fifo_level, exp_valid, exp_len (R6, R7)
  localparam logic [20:0] VEC [10] = '{
    {3'd0, 2'd0, 1'b1, 6'd1,  1'b1, 8'd1},
    {3'd3, 2'd1, 1'b1, 6'd3,  1'b0, 8'd8},
    {3'd3, 2'd1, 1'b1, 6'd4,  1'b1, 8'd8},
    {3'd7, 2'd3, 1'b1, 6'd16, 1'b1, 8'd128},
    {3'd7, 2'd3, 1'b1, 6'd15, 1'b0, 8'd128},
    {3'd5, 2'd2, 1'b0, 6'd24, 1'b1, 8'd32},
    {3'd5, 2'd2, 1'b0, 6'd25, 1'b0, 8'd32},
    {3'd2, 2'd3, 1'b0, 6'd16, 1'b1, 8'd4},
    {3'd6, 2'd0, 1'b0, 6'd32, 1'b0, 8'd64},
    {3'd4, 2'd0, 1'b0, 6'd31, 1'b1, 8'd16}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic beat();
    beat_ok = 1'b1;
    tick();
    beat_ok = 1'b0;
    if (period_pulse) pulses++;
  endtask

  task automatic start(input logic [AW-1:0] b, input logic [AW-1:0] p, input logic [11:0] pg);
    xfer_en = 1'b0;
    cfg_base = b; cfg_prot = p; cfg_page = pg;
    tick();
    xfer_en = 1'b1;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ptr", cur_ptr, 0);
    check("R1 req", req_valid, 0);
    check("R1 pulse", period_pulse, 0);
    check("R1 sts", period_sts, 0);
    rst_n = 1'b1;
    tick();

    // R6 R7 table of request vectors, ring far from limiting
    start(32'h2000, 32'h3000, 12'h000);
    for (int i = 0; i < 10; i++) begin
      burst_code = VEC[i][20:18];
      thresh_code = VEC[i][17:16];
      dir_write = VEC[i][15];
      fifo_level = VEC[i][14:9];
      tick();
      check("R7 req_valid", req_valid, VEC[i][8]);
      if (VEC[i][8]) check("R6 req_len", req_len, VEC[i][7:0]);
    end

    // R2 start and stepping
    dir_write = 1'b1; fifo_level = 6'd32; thresh_code = 2'd0;
    start(32'h1000, 32'h1040, 12'h010);
    check("R2 load base", cur_ptr, 32'h1000);
    beat();
    check("R2 step", cur_ptr, 32'h1004);
    // R6 burst cut at protection address: 15 dwords left
    burst_code = 3'd4;
    tick();
    check("R6 shortened", req_len, 15);
    check("R6 valid", req_valid, 1);
    pulses = 0;
    for (int i = 0; i < 14; i++) beat();
    check("R2 walk", cur_ptr, 32'h103C);
    burst_code = 3'd7;
    tick();
    check("R6 last dword", req_len, 1);
    check("R4 no early pulse", pulses, 0);
    // R3 wrap coincides with R4 period pulse
    beat();
    check("R3 wrap", cur_ptr, 32'h1000);
    check("R4 pulse at wrap", period_pulse, 1);
    tick();
    check("R4 one cycle", period_pulse, 0);
    check("R5 sts set", period_sts, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R5 cleared", period_sts, 0);
    // R5 clear colliding with pulse
    for (int i = 0; i < 15; i++) beat();
    beat();
    check("R4 pulse again", period_pulse, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R5 set wins", period_sts, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R5 cleared again", period_sts, 0);

    // R4 L=2 with MMU bit set: 128-byte crossings over 256-byte ring
    start(32'h1000, 32'h1100, 12'h820);
    pulses = 0;
    for (int i = 0; i < 64; i++) beat();
    check("R4 L2 count", pulses, 2);
    check("R3 ring back", cur_ptr, 32'h1000);
    // R4 L=1 with MMU bit set
    start(32'h1000, 32'h1100, 12'h810);
    pulses = 0;
    for (int i = 0; i < 64; i++) beat();
    check("R4 L1 mmu ignored", pulses, 4);
    // R4 L=0 never pulses
    start(32'h1000, 32'h1100, 12'h800);
    pulses = 0;
    for (int i = 0; i < 64; i++) beat();
    check("R4 L0 silent", pulses, 0);

    // R8 disable holds pointer and blocks requests
    start(32'h1000, 32'h1100, 12'h010);
    beat(); beat();
    xfer_en = 1'b0;
    tick();
    check("R8 no req", req_valid, 0);
    beat();
    check("R8 hold", cur_ptr, 32'h1008);

    // R9 invalid configurations
    start(32'h1000, 32'h1000, 12'h010);
    check("R9 err equal", cfg_err, 1);
    check("R9 no req", req_valid, 0);
    beat();
    check("R9 beat ignored", cur_ptr, 32'h1000);
    cfg_base = 32'h1002; cfg_prot = 32'h1040;
    tick();
    check("R9 err misaligned", cfg_err, 1);
    cfg_base = 32'h1000;
    tick();
    check("R9 err clear", cfg_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule